// File: doc/BRIEF.md
# Synchronous Character Hunt Detector

This block finds character alignment in a synchronous serial bit stream and then cuts that stream into characters at fixed boundaries. The receive bit arrives on `rxd` and is taken only in a cycle where `bit_en` is high. `bit_en` marks the sampling point, which is the middle of a bit. While hunting with internal detection, the block compares the most recent character-length window against the first sync character at every bit. With double sync programmed, the character that follows at once must equal the second sync character. If it does not, hunting starts again. When alignment is found, `syndet` goes high and the block then emits one `char_strobe` per character, with the assembled character on `char_data`.

In external mode the internal comparator does nothing, and the shared sync pin becomes an input: `syndet_oe` goes low. A high `syndet_in` at a bit sample ends the hunt. Character assembly starts with the next sampled bit. A sticky flag records every bit time at which the pin is seen high. In both modes a status-read pulse clears `syndet` and leaves the alignment unchanged. After alignment, internal sync detection still runs, but only at character boundaries. An enter-hunt command fills every used bit of the receive buffer with ones, so stale data cannot produce a false match. The block also hunts on its own after reset.

Top module: `sync_hunt_det`

## Requirements
- R1: After reset with `sync_mode`=1 the block is hunting (`in_hunt`=1), `syndet`=0, `char_strobe`=0, and `syndet_oe`=1, which means the pin is an output driven low.
- R2: When `sync_mode`=1, a `hunt_cmd` pulse enters hunt and sets every used bit of the receive buffer to one. With sync character 1 equal to all ones at the programmed length, one received 1 bit right after the command completes a match.
- R3: With parity off and single sync, hunting compares the last L received bits with sync character 1 at every bit. The first bit received is the least significant. L is 5 + `len_sel`, so `len_sel` 0 to 3 selects 5 to 8 bits. In the cycle after the `bit_en` that completes a match, `syndet`=1 and `in_hunt`=0.
- R4: With parity on (`par_en`=1), a match on the data bits is followed by one parity bit, whose value is ignored. `syndet` stays 0 after the last data bit and goes high only after the parity bit is sampled.
- R5: With double sync (`single_sync`=0), the character that follows sync character 1 directly must equal sync character 2. Any other character returns the block to hunting with `syndet` still 0. The two sync characters received back to back then end the hunt and set `syndet`.
- R6: A `stat_rd` pulse clears `syndet` in the next cycle, and `in_hunt` stays 0.
- R7: Once out of hunt, each frame is L data bits plus one parity bit when `par_en`=1. One cycle after the final bit of each frame, `char_strobe` pulses high for one cycle. `char_data` then holds the data bits, first bit in bit 0, and zeros above bit L-1. No strobe follows any other bit.
- R8: Once out of hunt, sync detection is checked only at frame boundaries. An aligned frame equal to sync character 1 sets `syndet` in single mode. In double mode, an aligned sync character 2 sets `syndet` only when the frame before it was sync character 1. A sync pattern that straddles two frames does not set `syndet`.
- R9: With `ext_sync`=1, `syndet_oe`=0 and sync characters on `rxd` do not end the hunt. `syndet_in` high at a bit sample ends the hunt and sets `syndet`. The next L bits form the first character. Out of hunt, `syndet_in` high at any bit sample sets `syndet` again.
- R10: When `sync_mode`=0, `hunt_cmd` has no effect: after returning to `sync_mode`=1, the block is still out of hunt.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe at the sampling point of a received bit |
| rxd | input | 1 | Received serial bit |
| sync_mode | input | 1 | 1 = synchronous operation programmed |
| len_sel | input | 2 | Character length minus five |
| par_en | input | 1 | A parity bit follows each character |
| single_sync | input | 1 | 1 = one sync character, 0 = two |
| ext_sync | input | 1 | 1 = alignment from the external pin |
| sync1 | input | 8 | First sync character, low L bits used |
| sync2 | input | 8 | Second sync character, low L bits used |
| hunt_cmd | input | 1 | Enter-hunt command pulse |
| stat_rd | input | 1 | Status-read pulse |
| syndet_in | input | 1 | Sync pin value when used as an input |
| in_hunt | output | 1 | Block is searching for alignment |
| syndet | output | 1 | Sync-detected flag, also drives the pin in output mode |
| syndet_oe | output | 1 | 1 = sync pin driven by the block |
| char_strobe | output | 1 | One-cycle pulse after each completed frame |
| char_data | output | 8 | Character assembled in the last frame |

## Verification
The assertions assume that reset holds `hunt_cmd` and `stat_rd` low. They also assume that a status read not taken in a `bit_en` cycle carries no new sync event, since a set in the same cycle would win over the clear. The bench meets both conditions. It separates every `bit_en` from the next by an idle cycle, issues commands and reads only in idle cycles, and changes the mode fields only between test groups. It picks odd sync values that are not all ones, so that no shifted prefix of the stream can match before the intended bit.

// File: rtl/sync_hunt_pkg.sv
package sync_hunt_pkg;

    localparam int CHAR_W  = 8;
    localparam int MIN_LEN = CHAR_W - 3;
    localparam int POS_W   = $clog2(CHAR_W + 2);

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_PAR1,
        ST_SYNC2,
        ST_RUN
    } hunt_st_e;

    typedef struct packed {
        logic [1:0] len_sel;
        logic       par_en;
        logic       single;
        logic       ext;
    } hunt_cfg_t;

    function automatic logic [POS_W-1:0] char_len(input logic [1:0] ls);
        return POS_W'(ls) + POS_W'(MIN_LEN);
    endfunction

    function automatic logic [CHAR_W-1:0] len_mask(input logic [POS_W-1:0] len);
        logic [CHAR_W-1:0] m;
        for (int i = 0; i < CHAR_W; i++) begin
            m[i] = (i < int'(len));
        end
        return m;
    endfunction

endpackage

// File: rtl/sync_shreg.sv
module sync_shreg
    import sync_hunt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              preset,
    input  logic              shift,
    input  logic              rxd,
    input  logic [POS_W-1:0]  len,
    input  logic [CHAR_W-1:0] mask,
    output logic [CHAR_W-1:0] q,
    output logic [CHAR_W-1:0] nxt
);
    logic [CHAR_W-1:0] shr;

    always_comb begin
        shr = q >> 1;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i == int'(len) - 1) nxt[i] = rxd;
            else                    nxt[i] = shr[i] & mask[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)         q <= '1;
        else if (preset) q <= mask;
        else if (shift)  q <= nxt;
    end
endmodule

// File: rtl/sync_bitpos.sv
module sync_bitpos
    import sync_hunt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             par_ld,
    input  logic             step,
    input  logic [POS_W-1:0] len,
    input  logic             par_en,
    output logic             last,
    output logic             in_data
);
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] last_pos;

    assign last_pos = len - POS_W'(1) + POS_W'(par_en);
    assign last     = (pos == last_pos);
    assign in_data  = (pos < len);

    always_ff @(posedge clk) begin
        if (rst || clr)  pos <= '0;
        else if (par_ld) pos <= len;
        else if (step)   pos <= last ? '0 : pos + POS_W'(1);
    end
endmodule

// File: rtl/sync_flag.sv
module sync_flag (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic q
);
    always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= set | (q & ~clr);
    end
endmodule

// File: rtl/sync_hunt_det.sv
module sync_hunt_det
    import sync_hunt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_en,
    input  logic              rxd,
    input  logic              sync_mode,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              single_sync,
    input  logic              ext_sync,
    input  logic [CHAR_W-1:0] sync1,
    input  logic [CHAR_W-1:0] sync2,
    input  logic              hunt_cmd,
    input  logic              stat_rd,
    input  logic              syndet_in,
    output logic              in_hunt,
    output logic              syndet,
    output logic              syndet_oe,
    output logic              char_strobe,
    output logic [CHAR_W-1:0] char_data
);
    hunt_cfg_t         cfg;
    hunt_st_e          st, st_n;
    logic [POS_W-1:0]  len;
    logic [CHAR_W-1:0] mask, sr_q, sr_nxt, s1m, s2m, cval;
    logic bit_act, int_hunt, framing, shift, match1, frame_end, cmd_hunt;
    logic found1, ext_entry, pos_clr, pos_par, pos_step, last, in_data;
    logic int_set, ext_hit, prev1;

    assign cfg      = '{len_sel: len_sel, par_en: par_en, single: single_sync, ext: ext_sync};
    assign len      = char_len(cfg.len_sel);
    assign mask     = len_mask(len);
    assign s1m      = sync1 & mask;
    assign s2m      = sync2 & mask;

    assign bit_act  = bit_en & sync_mode;
    assign cmd_hunt = hunt_cmd & sync_mode;
    assign int_hunt = (st == ST_HUNT) & ~cfg.ext;
    assign framing  = (st == ST_SYNC2) | (st == ST_RUN);
    assign shift    = bit_act & (int_hunt | (framing & in_data));
    assign match1   = (sr_nxt == s1m);
    assign cval     = cfg.par_en ? sr_q : sr_nxt;
    assign frame_end = bit_act & framing & last;
    assign ext_hit  = bit_act & cfg.ext & syndet_in;
    assign ext_entry = (st == ST_HUNT) & ext_hit;

    always_comb begin
        st_n   = st;
        found1 = 1'b0;
        if (cmd_hunt) begin
            st_n = ST_HUNT;
        end else begin
            case (st)
                ST_HUNT: begin
                    if (ext_entry)                   st_n = ST_RUN;
                    else if (int_hunt && bit_act && match1) begin
                        if (cfg.par_en) st_n = ST_PAR1;
                        else            found1 = 1'b1;
                    end
                end
                ST_PAR1:  if (bit_act) found1 = 1'b1;
                ST_SYNC2: if (frame_end) st_n = (cval == s2m) ? ST_RUN : ST_HUNT;
                default:  ;
            endcase
            if (found1) st_n = cfg.single ? ST_RUN : ST_SYNC2;
        end
    end

    assign pos_clr  = cmd_hunt | found1 | ext_entry;
    assign pos_par  = (st == ST_HUNT) & (st_n == ST_PAR1);
    assign pos_step = bit_act & framing & ~cmd_hunt;

    always_comb begin
        int_set = 1'b0;
        if (!cfg.ext) begin
            if (found1 && cfg.single) int_set = 1'b1;
            if (frame_end && st == ST_SYNC2 && cval == s2m) int_set = 1'b1;
            if (frame_end && st == ST_RUN) begin
                if (cfg.single) int_set = (cval == s1m);
                else            int_set = prev1 & (cval == s2m);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st          <= ST_HUNT;
            prev1       <= 1'b0;
            char_strobe <= 1'b0;
        end else begin
            st          <= st_n;
            char_strobe <= frame_end & (st == ST_RUN) & ~cmd_hunt;
            if (cmd_hunt || st != ST_RUN) prev1 <= 1'b0;
            else if (frame_end)           prev1 <= (cval == s1m);
        end
    end

    sync_shreg u_shreg (
        .clk(clk), .rst(rst), .preset(cmd_hunt), .shift(shift), .rxd(rxd),
        .len(len), .mask(mask), .q(sr_q), .nxt(sr_nxt)
    );

    sync_bitpos u_pos (
        .clk(clk), .rst(rst), .clr(pos_clr), .par_ld(pos_par), .step(pos_step),
        .len(len), .par_en(cfg.par_en), .last(last), .in_data(in_data)
    );

    sync_flag u_flag (
        .clk(clk), .rst(rst), .set(int_set | ext_hit), .clr(stat_rd), .q(syndet)
    );

    assign in_hunt   = sync_mode & (st != ST_RUN);
    assign syndet_oe = ~(sync_mode & cfg.ext);
    assign char_data = sr_q & mask;
endmodule

// File: rtl/sync_hunt_chk.sv
module sync_hunt_chk (
    input logic clk,
    input logic rst,
    input logic bit_en,
    input logic sync_mode,
    input logic hunt_cmd,
    input logic stat_rd,
    input logic in_hunt,
    input logic syndet,
    input logic char_strobe
);
    AST_HUNT_ON_CMD: assert property (@(posedge clk) disable iff (rst)
        (hunt_cmd && sync_mode) |=> (in_hunt || !sync_mode)); // R2

    AST_SYNDET_AT_BIT: assert property (@(posedge clk) disable iff (rst)
        $rose(syndet) |-> $past(bit_en && sync_mode)); // R3

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !bit_en) |=> !syndet); // R6

    AST_READ_KEEPS_ALIGN: assert property (@(posedge clk) disable iff (rst)
        (stat_rd && !in_hunt && !hunt_cmd && !bit_en) |=> (!in_hunt || !sync_mode)); // R6

    AST_STROBE_AT_BIT: assert property (@(posedge clk) disable iff (rst)
        char_strobe |-> $past(bit_en && !in_hunt)); // R7
endmodule

bind sync_hunt_det sync_hunt_chk u_chk (
    .clk(clk), .rst(rst), .bit_en(bit_en), .sync_mode(sync_mode),
    .hunt_cmd(hunt_cmd), .stat_rd(stat_rd), .in_hunt(in_hunt),
    .syndet(syndet), .char_strobe(char_strobe)
);

// File: tb/sync_hunt_det_tb.sv
module sync_hunt_det_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_en = 1'b0, rxd = 1'b0, sync_mode = 1'b1;
    logic [1:0] len_sel = 2'd3;
    logic par_en = 1'b0, single_sync = 1'b1, ext_sync = 1'b0;
    logic [7:0] sync1 = 8'h95, sync2 = 8'h6B;
    logic hunt_cmd = 1'b0, stat_rd = 1'b0, syndet_in = 1'b0;
    logic in_hunt, syndet, syndet_oe, char_strobe;
    logic [7:0] char_data;

    int n_chk = 0, n_fail = 0, cyc = 0;
    bit done = 0;
    logic last_strobe;
    logic [7:0] last_data;
    int early;

    always #5 clk = ~clk;

    sync_hunt_det u_dut (
        .clk(clk), .rst(rst), .bit_en(bit_en), .rxd(rxd), .sync_mode(sync_mode),
        .len_sel(len_sel), .par_en(par_en), .single_sync(single_sync),
        .ext_sync(ext_sync), .sync1(sync1), .sync2(sync2), .hunt_cmd(hunt_cmd),
        .stat_rd(stat_rd), .syndet_in(syndet_in), .in_hunt(in_hunt),
        .syndet(syndet), .syndet_oe(syndet_oe), .char_strobe(char_strobe),
        .char_data(char_data)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog act=%0d exp=<100000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send_bit(input logic b, input logic ext_in);
        rxd = b; syndet_in = ext_in; bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0; syndet_in = 1'b0;
        last_strobe = char_strobe;
        last_data   = char_data;
        @(negedge clk);
    endtask

    task automatic send_char(input logic [7:0] v, input int L, input logic p);
        early = 0;
        for (int i = 0; i < L; i++) begin
            send_bit(v[i], 1'b0);
            if (last_strobe && (p || i != L - 1)) early++;
        end
        if (p) send_bit(1'b0, 1'b0);
    endtask

    task automatic pulse_hunt();
        hunt_cmd = 1'b1; tick(); hunt_cmd = 1'b0;
    endtask

    task automatic pulse_read();
        stat_rd = 1'b1; tick(); stat_rd = 1'b0;
    endtask

    task automatic config_mode(input int L, input logic p, input logic s, input logic e);
        len_sel = 2'(L - 5); par_en = p; single_sync = s; ext_sync = e;
    endtask

    initial begin
        logic [7:0] m, s1m, s2m, d;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        check("R1 in_hunt", in_hunt, 1);
        check("R1 syndet", syndet, 0);
        check("R1 strobe", char_strobe, 0);
        check("R1 syndet_oe", syndet_oe, 1);

        for (int L = 5; L <= 8; L++) begin
            for (int p = 0; p < 2; p++) begin
                config_mode(L, 1'(p), 1'b1, 1'b0);
                m = 8'((1 << L) - 1);
                s1m = sync1 & m;
                pulse_hunt();
                check("R2 hunt entered", in_hunt, 1);
                send_char(8'h00, L, 1'b0);
                check("R3 no early match", syndet, 0);
                for (int i = 0; i < L; i++) send_bit(s1m[i], 1'b0);
                if (p == 1) begin
                    check("R4 not at last data bit", syndet, 0);
                    check("R4 still hunting", in_hunt, 1);
                    send_bit(1'b1, 1'b0);
                    check("R4 syndet at parity", syndet, 1);
                    check("R4 hunt ended", in_hunt, 0);
                end else begin
                    check("R3 syndet", syndet, 1);
                    check("R3 hunt ended", in_hunt, 0);
                end
                pulse_read();
                check("R6 cleared", syndet, 0);
                check("R6 alignment kept", in_hunt, 0);
                for (int k = 0; k < 3; k++) begin
                    d = 8'((k * 37 + L * 11 + p * 5) & int'(m));
                    send_char(d, L, 1'(p));
                    check("R7 no mid strobe", early, 0);
                    check("R7 strobe", last_strobe, 1);
                    check("R7 data", last_data, d);
                end
                pulse_read();
                send_char(s1m, L, 1'(p));
                check("R8 aligned sync", syndet, 1);
                pulse_read();
                send_char((s1m << 2) & m, L, 1'(p));
                send_char(s1m >> (L - 2), L, 1'(p));
                check("R8 straddled sync ignored", syndet, 0);
            end
        end

        for (int c = 0; c < 2; c++) begin
            int L;
            logic p;
            L = (c == 0) ? 8 : 6;
            p = (c == 0) ? 1'b0 : 1'b1;
            config_mode(L, p, 1'b0, 1'b0);
            m = 8'((1 << L) - 1);
            s1m = sync1 & m;
            s2m = sync2 & m;
            pulse_hunt();
            send_char(8'h00, L, 1'b0);
            send_char(s1m, L, p);
            check("R5 one sync not enough", in_hunt, 1);
            check("R5 no syndet yet", syndet, 0);
            send_char(8'h00, L, p);
            check("R5 wrong second resumes hunt", in_hunt, 1);
            check("R5 wrong second no syndet", syndet, 0);
            send_char(s1m, L, p);
            send_char(s2m, L, p);
            check("R5 pair syndet", syndet, 1);
            check("R5 pair ends hunt", in_hunt, 0);
            pulse_read();
            send_char(s2m, L, p);
            check("R8 lone second sync ignored", syndet, 0);
            send_char(s1m, L, p);
            send_char(s2m, L, p);
            check("R8 aligned pair", syndet, 1);
            pulse_read();
        end

        config_mode(5, 1'b0, 1'b1, 1'b0);
        sync1 = 8'h1F;
        send_char(8'h00, 5, 1'b0);
        pulse_read();
        pulse_hunt();
        send_bit(1'b1, 1'b0);
        check("R2 preset ones match", syndet, 1);
        check("R2 hunt ended", in_hunt, 0);
        pulse_read();

        sync1 = 8'h95;
        config_mode(7, 1'b0, 1'b1, 1'b1);
        tick();
        check("R9 pin is input", syndet_oe, 0);
        pulse_hunt();
        send_char(8'h15, 7, 1'b0);
        check("R9 internal detect off", in_hunt, 1);
        check("R9 internal detect no flag", syndet, 0);
        send_bit(1'b1, 1'b1);
        check("R9 external ends hunt", in_hunt, 0);
        check("R9 external flag", syndet, 1);
        pulse_read();
        send_char(8'h5A & 8'h7F, 7, 1'b0);
        check("R9 first char strobe", last_strobe, 1);
        check("R9 first char data", last_data, 8'h5A);
        check("R9 first char no early", early, 0);
        check("R9 flag cleared", syndet, 0);
        send_bit(1'b0, 1'b1);
        check("R9 any boundary sets", syndet, 1);
        pulse_read();

        config_mode(7, 1'b0, 1'b1, 1'b0);
        tick();
        check("R1 pin output again", syndet_oe, 1);
        sync_mode = 1'b0;
        tick();
        pulse_hunt();
        sync_mode = 1'b1;
        tick();
        check("R10 hunt ignored", in_hunt, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule